// File: doc/BRIEF.md
# Instruction Opcode Decoder

This block turns the opcode field of an accumulator machine's instruction word into the control fields that steer the rest of the processor. An instruction word holds an 8-bit opcode and an operand of up to 32 bits. Only the opcode reaches this block. Its upper two bits are reserved and have no effect. The lower six bits select one of 39 defined operations.

For each code the block produces several outputs together:

- a datapath command: ALU operation, operand source, and the accumulator and B-register write controls;
- a memory command: address source, write enable and stack-pointer update;
- a control-flow command: next-PC source, branch condition and flag-clear strobes.

The block is purely combinational and holds no state. Every code outside the defined set decodes exactly like NOP. The NOP decode is all zeros on every output.

Top module: `opc_decoder`

## Requirements
- R1: Bits 7:6 of `opcode_i` have no effect: any two opcodes that share bits 5:0 give identical values on all outputs.
- R2: Add and subtract codes decode to ALU op 1 (add) or 2 (subtract) with `wr_acc_o`=1. The operand source is 0 (B) for codes 0x00/0x03, 1 (memory) for 0x01/0x04, and 2 (operand) for 0x02/0x05. Increment 0x06 is add and decrement 0x07 is subtract, both with source 3 (constant one).
- R3: Single-result ALU codes set `wr_acc_o`=1 with these ALU ops:
  - AND 0x08 → 3, OR 0x09 → 4, XOR 0x0A → 5 (all with source 0);
  - invert 0x0B → 6, negate 0x0C → 7;
  - arithmetic right 0x16 → 8, arithmetic left 0x17 → 9;
  - logical right 0x18 → 10, logical left 0x19 → 11;
  - rotate right through carry 0x21 → 12, rotate left through carry 0x22 → 13;
  - clear accumulator 0x20 → 14.
- R4: Codes that take a memory operand or load/store at the operand address give `addr_sel_o`=1 (operand address). These are 0x01, 0x04, 0x1A, 0x1B and 0x1D. Load-A 0x1A uses ALU op 0 (pass), source 1, and `wr_acc_o`=1.
- R5: `mem_we_o` is 1 only for store 0x1B and PUSH 0x3C.
- R6: PUSH 0x3C gives `addr_sel_o`=2 (SP), `mem_we_o`=1 and `sp_op_o`=1 (increment). POP 0x3D gives `addr_sel_o`=3 (SP-1), ALU pass with source 1, `wr_acc_o`=1 and `sp_op_o`=2 (decrement).
- R7: Next-PC sources:
  - 0x0D/0x0E/0x0F/0x11/0x1E give `pc_sel_o`=1 (absolute operand), with `br_cond_o` 0 (always), 1 (Z), 2 (OV), 4 (EQ) and 3 (C) respectively;
  - 0x10 gives `pc_sel_o`=2 (PC plus operand);
  - 0x14 gives `pc_sel_o`=3 (from A);
  - HALT 0x3F gives `pc_sel_o`=4 (hold);
  - every other code gives `pc_sel_o`=0 (PC+1) and `br_cond_o`=0.
- R8: `flag_clr_o` bit 0 (Z) is set by 0x12, bit 1 (OV) by 0x13 and bit 2 (C) by 0x1F. At most one bit is ever set, and these codes assert no write.
- R9: Load-B codes set `wr_b_o`=1. Code 0x1C sets `b_src_o`=0 (operand). Code 0x1D sets `b_src_o`=1 (memory). Neither writes A nor memory.
- R10: Save-PC 0x15 decodes to ALU pass with source 4 (PC) and `wr_acc_o`=1.
- R11: NOP 0x3E and every undefined code (0x23 to 0x3B) drive every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 8 | Opcode field; bits 7:6 reserved |
| alu_op_o | output | 4 | ALU operation code |
| src_sel_o | output | 3 | ALU second-operand source |
| wr_acc_o | output | 1 | Write result into accumulator A |
| wr_b_o | output | 1 | Write register B |
| b_src_o | output | 1 | B load source: 0 operand, 1 memory |
| addr_sel_o | output | 2 | Memory address source |
| mem_we_o | output | 1 | Write A into memory |
| pc_sel_o | output | 3 | Next-PC source |
| br_cond_o | output | 3 | Flag that qualifies an absolute jump |
| sp_op_o | output | 2 | Stack-pointer update |
| flag_clr_o | output | 3 | Flag-clear strobes {C, OV, Z} |

## Verification
The checks assume the opcode is fully defined; any cycle where the opcode holds an unknown bit is skipped. They also assume the decoder has settled for the current opcode, since there is no clock or reset inside the block. The stimulus drives only fully known 8-bit values, changes them on one clock edge and reads the outputs half a period later. It walks every defined code, several with the reserved bits set, and then every 6-bit code under all four reserved-bit patterns.

// File: rtl/opc_dec_pkg.sv
package opc_dec_pkg;

    localparam int OPCODE_W = 8;
    localparam int CODE_W   = 6;
    localparam int ALU_W    = 4;
    localparam int SRC_W    = 3;
    localparam int ADDR_W   = 2;
    localparam int PC_W     = 3;
    localparam int COND_W   = 3;
    localparam int SP_W     = 2;
    localparam int NCLR     = 3;

    typedef enum logic [ALU_W-1:0] {
        ALU_PASS = 4'd0,  ALU_ADD = 4'd1,  ALU_SUB = 4'd2,  ALU_AND = 4'd3,
        ALU_OR   = 4'd4,  ALU_XOR = 4'd5,  ALU_NOT = 4'd6,  ALU_NEG = 4'd7,
        ALU_SAR  = 4'd8,  ALU_SAL = 4'd9,  ALU_SHR = 4'd10, ALU_SHL = 4'd11,
        ALU_RRC  = 4'd12, ALU_RLC = 4'd13, ALU_ZERO = 4'd14
    } alu_op_e;

    typedef enum logic [SRC_W-1:0] {
        SRC_B = 3'd0, SRC_MEM = 3'd1, SRC_IMM = 3'd2, SRC_ONE = 3'd3, SRC_PC = 3'd4
    } src_e;

    typedef enum logic [ADDR_W-1:0] {
        ADR_NONE = 2'd0, ADR_IMM = 2'd1, ADR_SP = 2'd2, ADR_SPM1 = 2'd3
    } addr_e;

    typedef enum logic [PC_W-1:0] {
        PC_INC = 3'd0, PC_ABS = 3'd1, PC_REL = 3'd2, PC_ACC = 3'd3, PC_HOLD = 3'd4
    } pc_e;

    typedef enum logic [COND_W-1:0] {
        CND_ALWAYS = 3'd0, CND_Z = 3'd1, CND_OV = 3'd2, CND_C = 3'd3, CND_EQ = 3'd4
    } cond_e;

    typedef enum logic [SP_W-1:0] {
        SP_HOLD = 2'd0, SP_INC = 2'd1, SP_DEC = 2'd2
    } sp_e;

    // Six-bit operation codes
    localparam logic [CODE_W-1:0] OP_ADD_B   = 6'h00;
    localparam logic [CODE_W-1:0] OP_ADD_M   = 6'h01;
    localparam logic [CODE_W-1:0] OP_ADD_I   = 6'h02;
    localparam logic [CODE_W-1:0] OP_SUB_B   = 6'h03;
    localparam logic [CODE_W-1:0] OP_SUB_M   = 6'h04;
    localparam logic [CODE_W-1:0] OP_SUB_I   = 6'h05;
    localparam logic [CODE_W-1:0] OP_INC     = 6'h06;
    localparam logic [CODE_W-1:0] OP_DEC     = 6'h07;
    localparam logic [CODE_W-1:0] OP_AND     = 6'h08;
    localparam logic [CODE_W-1:0] OP_OR      = 6'h09;
    localparam logic [CODE_W-1:0] OP_XOR     = 6'h0A;
    localparam logic [CODE_W-1:0] OP_INV     = 6'h0B;
    localparam logic [CODE_W-1:0] OP_NEG     = 6'h0C;
    localparam logic [CODE_W-1:0] OP_JMP     = 6'h0D;
    localparam logic [CODE_W-1:0] OP_JZ      = 6'h0E;
    localparam logic [CODE_W-1:0] OP_JOV     = 6'h0F;
    localparam logic [CODE_W-1:0] OP_JREL    = 6'h10;
    localparam logic [CODE_W-1:0] OP_JEQ     = 6'h11;
    localparam logic [CODE_W-1:0] OP_CLR_Z   = 6'h12;
    localparam logic [CODE_W-1:0] OP_CLR_OV  = 6'h13;
    localparam logic [CODE_W-1:0] OP_PC_A    = 6'h14;
    localparam logic [CODE_W-1:0] OP_A_PC    = 6'h15;
    localparam logic [CODE_W-1:0] OP_SAR     = 6'h16;
    localparam logic [CODE_W-1:0] OP_SAL     = 6'h17;
    localparam logic [CODE_W-1:0] OP_SHR     = 6'h18;
    localparam logic [CODE_W-1:0] OP_SHL     = 6'h19;
    localparam logic [CODE_W-1:0] OP_LD_A    = 6'h1A;
    localparam logic [CODE_W-1:0] OP_ST_A    = 6'h1B;
    localparam logic [CODE_W-1:0] OP_LD_B_I  = 6'h1C;
    localparam logic [CODE_W-1:0] OP_LD_B_M  = 6'h1D;
    localparam logic [CODE_W-1:0] OP_JC      = 6'h1E;
    localparam logic [CODE_W-1:0] OP_CLR_C   = 6'h1F;
    localparam logic [CODE_W-1:0] OP_ZERO_A  = 6'h20;
    localparam logic [CODE_W-1:0] OP_RRC     = 6'h21;
    localparam logic [CODE_W-1:0] OP_RLC     = 6'h22;
    localparam logic [CODE_W-1:0] OP_PUSH    = 6'h3C;
    localparam logic [CODE_W-1:0] OP_POP     = 6'h3D;
    localparam logic [CODE_W-1:0] OP_NOP     = 6'h3E;
    localparam logic [CODE_W-1:0] OP_HALT    = 6'h3F;

    // Flag-clear strobe i fires for CLR_CODES[i]: 0 = Z, 1 = OV, 2 = C
    localparam logic [CODE_W-1:0] CLR_CODES [NCLR] = '{OP_CLR_Z, OP_CLR_OV, OP_CLR_C};

    typedef struct packed {
        alu_op_e alu;
        src_e    src;
        logic    wr_acc;
        logic    wr_b;
        logic    b_mem;
    } dp_cmd_t;

    typedef struct packed {
        addr_e addr;
        logic  we;
        sp_e   sp;
    } mem_cmd_t;

    typedef struct packed {
        pc_e              pc;
        cond_e            cond;
        logic [NCLR-1:0]  clr;
    } flow_cmd_t;

endpackage

// File: rtl/opc_dp_dec.sv
module opc_dp_dec
    import opc_dec_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output dp_cmd_t           cmd_o
);

    dp_cmd_t cmd_d;

    always_comb begin
        cmd_d = '0;
        unique case (code_i)
            OP_ADD_B:  begin cmd_d.alu = ALU_ADD;  cmd_d.src = SRC_B;   cmd_d.wr_acc = 1'b1; end
            OP_ADD_M:  begin cmd_d.alu = ALU_ADD;  cmd_d.src = SRC_MEM; cmd_d.wr_acc = 1'b1; end
            OP_ADD_I:  begin cmd_d.alu = ALU_ADD;  cmd_d.src = SRC_IMM; cmd_d.wr_acc = 1'b1; end
            OP_SUB_B:  begin cmd_d.alu = ALU_SUB;  cmd_d.src = SRC_B;   cmd_d.wr_acc = 1'b1; end
            OP_SUB_M:  begin cmd_d.alu = ALU_SUB;  cmd_d.src = SRC_MEM; cmd_d.wr_acc = 1'b1; end
            OP_SUB_I:  begin cmd_d.alu = ALU_SUB;  cmd_d.src = SRC_IMM; cmd_d.wr_acc = 1'b1; end
            OP_INC:    begin cmd_d.alu = ALU_ADD;  cmd_d.src = SRC_ONE; cmd_d.wr_acc = 1'b1; end
            OP_DEC:    begin cmd_d.alu = ALU_SUB;  cmd_d.src = SRC_ONE; cmd_d.wr_acc = 1'b1; end
            OP_AND:    begin cmd_d.alu = ALU_AND;  cmd_d.wr_acc = 1'b1; end
            OP_OR:     begin cmd_d.alu = ALU_OR;   cmd_d.wr_acc = 1'b1; end
            OP_XOR:    begin cmd_d.alu = ALU_XOR;  cmd_d.wr_acc = 1'b1; end
            OP_INV:    begin cmd_d.alu = ALU_NOT;  cmd_d.wr_acc = 1'b1; end
            OP_NEG:    begin cmd_d.alu = ALU_NEG;  cmd_d.wr_acc = 1'b1; end
            OP_A_PC:   begin cmd_d.alu = ALU_PASS; cmd_d.src = SRC_PC;  cmd_d.wr_acc = 1'b1; end
            OP_SAR:    begin cmd_d.alu = ALU_SAR;  cmd_d.wr_acc = 1'b1; end
            OP_SAL:    begin cmd_d.alu = ALU_SAL;  cmd_d.wr_acc = 1'b1; end
            OP_SHR:    begin cmd_d.alu = ALU_SHR;  cmd_d.wr_acc = 1'b1; end
            OP_SHL:    begin cmd_d.alu = ALU_SHL;  cmd_d.wr_acc = 1'b1; end
            OP_LD_A:   begin cmd_d.alu = ALU_PASS; cmd_d.src = SRC_MEM; cmd_d.wr_acc = 1'b1; end
            OP_LD_B_I: begin cmd_d.wr_b = 1'b1;    cmd_d.b_mem = 1'b0; end
            OP_LD_B_M: begin cmd_d.wr_b = 1'b1;    cmd_d.b_mem = 1'b1; end
            OP_ZERO_A: begin cmd_d.alu = ALU_ZERO; cmd_d.wr_acc = 1'b1; end
            OP_RRC:    begin cmd_d.alu = ALU_RRC;  cmd_d.wr_acc = 1'b1; end
            OP_RLC:    begin cmd_d.alu = ALU_RLC;  cmd_d.wr_acc = 1'b1; end
            OP_POP:    begin cmd_d.alu = ALU_PASS; cmd_d.src = SRC_MEM; cmd_d.wr_acc = 1'b1; end
            default:   cmd_d = '0;
        endcase
    end

    assign cmd_o = cmd_d;

endmodule

// File: rtl/opc_mem_dec.sv
module opc_mem_dec
    import opc_dec_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output mem_cmd_t          cmd_o
);

    mem_cmd_t cmd_d;

    always_comb begin
        cmd_d = '0;
        unique case (code_i)
            OP_ADD_M, OP_SUB_M, OP_LD_A, OP_LD_B_M: cmd_d.addr = ADR_IMM;
            OP_ST_A: begin
                cmd_d.addr = ADR_IMM;
                cmd_d.we   = 1'b1;
            end
            OP_PUSH: begin
                cmd_d.addr = ADR_SP;
                cmd_d.we   = 1'b1;
                cmd_d.sp   = SP_INC;
            end
            OP_POP: begin
                cmd_d.addr = ADR_SPM1;
                cmd_d.sp   = SP_DEC;
            end
            default: cmd_d = '0;
        endcase
    end

    assign cmd_o = cmd_d;

endmodule

// File: rtl/opc_flow_dec.sv
module opc_flow_dec
    import opc_dec_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output flow_cmd_t         cmd_o
);

    flow_cmd_t       cmd_d;
    logic [NCLR-1:0] clr_d;

    // One comparator per flag-clear strobe
    for (genvar i = 0; i < NCLR; i++) begin : g_clr
        assign clr_d[i] = (code_i == CLR_CODES[i]);
    end

    always_comb begin
        cmd_d      = '0;
        cmd_d.clr  = clr_d;
        unique case (code_i)
            OP_JMP:  begin cmd_d.pc = PC_ABS; cmd_d.cond = CND_ALWAYS; end
            OP_JZ:   begin cmd_d.pc = PC_ABS; cmd_d.cond = CND_Z;      end
            OP_JOV:  begin cmd_d.pc = PC_ABS; cmd_d.cond = CND_OV;     end
            OP_JC:   begin cmd_d.pc = PC_ABS; cmd_d.cond = CND_C;      end
            OP_JEQ:  begin cmd_d.pc = PC_ABS; cmd_d.cond = CND_EQ;     end
            OP_JREL: cmd_d.pc = PC_REL;
            OP_PC_A: cmd_d.pc = PC_ACC;
            OP_HALT: cmd_d.pc = PC_HOLD;
            default: begin
                cmd_d.pc   = PC_INC;
                cmd_d.cond = CND_ALWAYS;
            end
        endcase
    end

    assign cmd_o = cmd_d;

endmodule

// File: rtl/opc_decoder.sv
module opc_decoder
    import opc_dec_pkg::*;
#(
    parameter int OPC_W = OPCODE_W
) (
    input  logic [OPC_W-1:0]  opcode_i,
    output logic [ALU_W-1:0]  alu_op_o,
    output logic [SRC_W-1:0]  src_sel_o,
    output logic              wr_acc_o,
    output logic              wr_b_o,
    output logic              b_src_o,
    output logic [ADDR_W-1:0] addr_sel_o,
    output logic              mem_we_o,
    output logic [PC_W-1:0]   pc_sel_o,
    output logic [COND_W-1:0] br_cond_o,
    output logic [SP_W-1:0]   sp_op_o,
    output logic [NCLR-1:0]   flag_clr_o
);

    localparam int RSVD_W = OPC_W - CODE_W;

    logic [CODE_W-1:0] code;
    logic              rsvd_unused;
    dp_cmd_t           dp_cmd;
    mem_cmd_t          mem_cmd;
    flow_cmd_t         flow_cmd;

    assign code        = opcode_i[CODE_W-1:0];
    assign rsvd_unused = ^opcode_i[OPC_W-1:OPC_W-RSVD_W];

    opc_dp_dec   u_dp   (.code_i(code), .cmd_o(dp_cmd));
    opc_mem_dec  u_mem  (.code_i(code), .cmd_o(mem_cmd));
    opc_flow_dec u_flow (.code_i(code), .cmd_o(flow_cmd));

    assign alu_op_o   = dp_cmd.alu;
    assign src_sel_o  = dp_cmd.src;
    assign wr_acc_o   = dp_cmd.wr_acc;
    assign wr_b_o     = dp_cmd.wr_b;
    assign b_src_o    = dp_cmd.b_mem;
    assign addr_sel_o = mem_cmd.addr;
    assign mem_we_o   = mem_cmd.we;
    assign sp_op_o    = mem_cmd.sp;
    assign pc_sel_o   = flow_cmd.pc;
    assign br_cond_o  = flow_cmd.cond;
    assign flag_clr_o = flow_cmd.clr;

endmodule

// File: rtl/opc_decoder_chk.sv
module opc_decoder_chk
    import opc_dec_pkg::*;
#(
    parameter int OPC_W = OPCODE_W
) (
    input logic [OPC_W-1:0]  opcode_i,
    input logic [ALU_W-1:0]  alu_op_o,
    input logic [SRC_W-1:0]  src_sel_o,
    input logic              wr_acc_o,
    input logic              wr_b_o,
    input logic              b_src_o,
    input logic [ADDR_W-1:0] addr_sel_o,
    input logic              mem_we_o,
    input logic [PC_W-1:0]   pc_sel_o,
    input logic [COND_W-1:0] br_cond_o,
    input logic [SP_W-1:0]   sp_op_o,
    input logic [NCLR-1:0]   flag_clr_o
);

    logic [CODE_W-1:0] code_c;
    assign code_c = opcode_i[CODE_W-1:0];

    always_comb begin
        if (!$isunknown(opcode_i)) begin
            // R5
            mem_we_addr_chk: assert (!mem_we_o || (addr_sel_o != ADR_NONE && !wr_acc_o));
            // R6
            sp_inc_chk: assert (sp_op_o != SP_INC || (addr_sel_o == ADR_SP && mem_we_o));
            // R6
            sp_dec_chk: assert (sp_op_o != SP_DEC ||
                                (addr_sel_o == ADR_SPM1 && wr_acc_o && src_sel_o == SRC_MEM));
            // R8
            one_clr_chk: assert ($onehot0(flag_clr_o));
            // R8
            clr_quiet_chk: assert (flag_clr_o == '0 ||
                                   (!wr_acc_o && !wr_b_o && !mem_we_o && pc_sel_o == PC_INC));
            // R7
            cond_abs_chk: assert (br_cond_o == CND_ALWAYS || pc_sel_o == PC_ABS);
            // R9
            b_load_chk: assert (!wr_b_o || (!wr_acc_o && !mem_we_o));
            // R4
            mem_src_addr_chk: assert (!(src_sel_o == SRC_MEM && wr_acc_o && sp_op_o == SP_HOLD)
                                      || addr_sel_o == ADR_IMM);
            // R11
            undef_zero_chk: assert (!(code_c >= 6'h23 && code_c <= 6'h3B) ||
                                    ({alu_op_o, src_sel_o, wr_acc_o, wr_b_o, b_src_o, addr_sel_o,
                                      mem_we_o, pc_sel_o, br_cond_o, sp_op_o, flag_clr_o} == '0));
        end
    end

endmodule

bind opc_decoder opc_decoder_chk #(.OPC_W(OPC_W)) u_chk (.*);

// File: tb/tb_opc_decoder.sv
module tb_opc_decoder;

    logic       clk = 1'b0;
    logic [7:0] opcode = 8'h3E;
    logic [3:0] alu_op;
    logic [2:0] src_sel;
    logic       wr_acc, wr_b, b_src;
    logic [1:0] addr_sel;
    logic       mem_we;
    logic [2:0] pc_sel, br_cond;
    logic [1:0] sp_op;
    logic [2:0] flag_clr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    opc_decoder dut (
        .opcode_i(opcode), .alu_op_o(alu_op), .src_sel_o(src_sel), .wr_acc_o(wr_acc),
        .wr_b_o(wr_b), .b_src_o(b_src), .addr_sel_o(addr_sel), .mem_we_o(mem_we),
        .pc_sel_o(pc_sel), .br_cond_o(br_cond), .sp_op_o(sp_op), .flag_clr_o(flag_clr)
    );

    typedef struct packed {
        logic [7:0] op;
        logic [3:0] alu;
        logic [2:0] src;
        logic       wa, wb, bs;
        logic [1:0] addr;
        logic       we;
        logic [2:0] pc, cond;
        logic [1:0] sp;
        logic [2:0] clr;
        int         req;
    } vec_t;

    localparam int NV = 41;
    // op, alu, src, wa, wb, bs, addr, we, pc, cond, sp, clr, requirement
    localparam vec_t VECS [NV] = '{
        '{8'h00, 4'd1,  3'd0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 3'd0, 3'd0, 2'd0, 3'b000, 2},  // R2
        '{8'h41, 4'd1,  3'd1, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 3'd0, 3'd0, 2'd0, 3'b000, 2},  // R2
        '{8'h82, 4'd1,  3'd2, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 3'd0, 3'd0, 2'd0, 3'b000, 2},  // R2
        '{8'hC3, 4'd2,  3'd0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 3'd0, 3'd0, 2'd0, 3'b000, 2},  // R2
        '{8'h04, 4'd2,  3'd1, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 3'd0, 3'd0, 2'd0, 3'b000, 4},  // R4
        '{8'h45, 4'd2,  3'd2, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 3'd0, 3'd0, 2'd0, 3'b000, 2},  // R2
        '{8'h86, 4'd1,  3'd3, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 3'd0, 3'd0, 2'd0, 3'b000, 2},  // R2
        '{8'h07, 4'd2,  3'd3, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 3'd0, 3'd0, 2'd0, 3'b000, 2},  // R2
        '{8'h08, 4'd3,  3'd0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 3'd0, 3'd0, 2'd0, 3'b000, 3},  // R3
        '{8'h09, 4'd4,  3'd0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 3'd0, 3'd0, 2'd0, 3'b000, 3},  // R3
        '{8'h4A, 4'd5,  3'd0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 3'd0, 3'd0, 2'd0, 3'b000, 3},  // R3
        '{8'h0B, 4'd6,  3'd0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 3'd0, 3'd0, 2'd0, 3'b000, 3},  // R3
        '{8'h0C, 4'd7,  3'd0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 3'd0, 3'd0, 2'd0, 3'b000, 3},  // R3
        '{8'h0D, 4'd0,  3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 3'd1, 3'd0, 2'd0, 3'b000, 7},  // R7
        '{8'h8E, 4'd0,  3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 3'd1, 3'd1, 2'd0, 3'b000, 7},  // R7
        '{8'h0F, 4'd0,  3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 3'd1, 3'd2, 2'd0, 3'b000, 7},  // R7
        '{8'h10, 4'd0,  3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 3'd2, 3'd0, 2'd0, 3'b000, 7},  // R7
        '{8'h11, 4'd0,  3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 3'd1, 3'd4, 2'd0, 3'b000, 7},  // R7
        '{8'h12, 4'd0,  3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 3'd0, 3'd0, 2'd0, 3'b001, 8},  // R8
        '{8'hD3, 4'd0,  3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 3'd0, 3'd0, 2'd0, 3'b010, 8},  // R8
        '{8'h14, 4'd0,  3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 3'd3, 3'd0, 2'd0, 3'b000, 7},  // R7
        '{8'h15, 4'd0,  3'd4, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 3'd0, 3'd0, 2'd0, 3'b000, 10}, // R10
        '{8'h16, 4'd8,  3'd0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 3'd0, 3'd0, 2'd0, 3'b000, 3},  // R3
        '{8'h17, 4'd9,  3'd0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 3'd0, 3'd0, 2'd0, 3'b000, 3},  // R3
        '{8'h18, 4'd10, 3'd0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 3'd0, 3'd0, 2'd0, 3'b000, 3},  // R3
        '{8'h59, 4'd11, 3'd0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 3'd0, 3'd0, 2'd0, 3'b000, 3},  // R3
        '{8'h1A, 4'd0,  3'd1, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 3'd0, 3'd0, 2'd0, 3'b000, 4},  // R4
        '{8'h1B, 4'd0,  3'd0, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 3'd0, 3'd0, 2'd0, 3'b000, 5},  // R5
        '{8'h1C, 4'd0,  3'd0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 3'd0, 3'd0, 2'd0, 3'b000, 9},  // R9
        '{8'h1D, 4'd0,  3'd0, 1'b0, 1'b1, 1'b1, 2'd1, 1'b0, 3'd0, 3'd0, 2'd0, 3'b000, 9},  // R9
        '{8'h1E, 4'd0,  3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 3'd1, 3'd3, 2'd0, 3'b000, 7},  // R7
        '{8'h1F, 4'd0,  3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 3'd0, 3'd0, 2'd0, 3'b100, 8},  // R8
        '{8'h20, 4'd14, 3'd0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 3'd0, 3'd0, 2'd0, 3'b000, 3},  // R3
        '{8'h21, 4'd12, 3'd0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 3'd0, 3'd0, 2'd0, 3'b000, 3},  // R3
        '{8'hA2, 4'd13, 3'd0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 3'd0, 3'd0, 2'd0, 3'b000, 3},  // R3
        '{8'h3C, 4'd0,  3'd0, 1'b0, 1'b0, 1'b0, 2'd2, 1'b1, 3'd0, 3'd0, 2'd1, 3'b000, 6},  // R6
        '{8'h7D, 4'd0,  3'd1, 1'b1, 1'b0, 1'b0, 2'd3, 1'b0, 3'd0, 3'd0, 2'd2, 3'b000, 6},  // R6
        '{8'h3E, 4'd0,  3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 3'd0, 3'd0, 2'd0, 3'b000, 11}, // R11
        '{8'hFF, 4'd0,  3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 3'd4, 3'd0, 2'd0, 3'b000, 7},  // R7
        '{8'h23, 4'd0,  3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 3'd0, 3'd0, 2'd0, 3'b000, 11}, // R11
        '{8'hBB, 4'd0,  3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 3'd0, 3'd0, 2'd0, 3'b000, 11}  // R11
    };

    function automatic logic [23:0] act_vec();
        return {alu_op, src_sel, wr_acc, wr_b, b_src, addr_sel, mem_we,
                pc_sel, br_cond, sp_op, flag_clr};
    endfunction

    task automatic check(input int req, input logic [7:0] op,
                         input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d opcode=%02h actual=%06h expected=%06h", req, op, act, exp);
        end
    endtask

    task automatic apply(input logic [7:0] op);
        @(posedge clk);
        opcode <= op;
        @(negedge clk);
    endtask

    initial begin
        logic [23:0] base;
        // R11: initial NOP opcode gives all-zero outputs
        @(negedge clk);
        check(11, opcode, act_vec(), 24'h0);

        // Table walk over defined codes (R2..R11)
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].op);
            check(VECS[i].req, VECS[i].op, act_vec(),
                  {VECS[i].alu, VECS[i].src, VECS[i].wa, VECS[i].wb, VECS[i].bs,
                   VECS[i].addr, VECS[i].we, VECS[i].pc, VECS[i].cond, VECS[i].sp,
                   VECS[i].clr});
        end

        // R11: every undefined code decodes to all zeros
        for (int c = 8'h23; c <= 8'h3B; c++) begin
            apply(8'(c));
            check(11, 8'(c), act_vec(), 24'h0);
        end

        // R1: reserved bits have no effect on any code
        for (int c = 0; c < 64; c++) begin
            apply({2'b00, 6'(c)});
            base = act_vec();
            for (int h = 1; h < 4; h++) begin
                apply({2'(h), 6'(c)});
                check(1, {2'(h), 6'(c)}, act_vec(), base);
            end
        end

        // R5: only store and PUSH raise the memory write across all codes
        for (int c = 0; c < 64; c++) begin
            apply({2'b00, 6'(c)});
            check(5, 8'(c), {23'h0, mem_we}, {23'h0, (c == 8'h1B || c == 8'h3C)});
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule